// File: doc/BRIEF.md
# Memory-Card Sub-Unit Command Responder

This block answers the memory sub-unit commands of a game-controller accessory. A frame receiver hands it whole command frames one 32-bit word at a time: a header word, then payload words, with a flag on any word that marks the frame as damaged. The block decodes the header, acts on an external word-wide RAM that holds the card's storage, and streams a response frame to a transmitter under a ready/valid handshake. Storage is divided into 512-byte blocks (128 words); a write carries one 128-byte quarter of a block (32 words), and a read returns a whole block in one response.

Write data is held in a 32-word staging buffer until the end of the frame, so a damaged frame, or one carrying the wrong function code, never touches the RAM. Irregular requests (a read naming a nonzero quarter, a write whose length field is not 34, or a write quarter above 3) set a sticky warning and are otherwise processed as usual.

Top module: `mc_responder`

## Requirements
- R1: A frame starts with a word flagged by `in_first`. Its header fields are command [7:0], destination [15:8], source [23:16] and length [31:24]. `in_ready` is high only while no frame is being handled. A frame whose destination bits [5:0] differ from 0x01 gets no response.
- R2: Every response starts with a header word in the same layout. Its source field is the request's destination, and its destination field is the request's source. `out_last` marks the final word. `out_valid` and `out_data` hold steady while `out_ready` is low.
- R3: Command 0x01 is answered with command 0x05 and length 28. The payload is `FUNC_ID`, `DESC_WORD`, two zero words, 23 words of 0x20202020, and then `PWR_WORD`.
- R4: Commands 0x02, 0x09 and 0x0A are answered with command 0x08 and length 7. The payload is `FUNC_ID` followed by six media words: 2^BLK_W−1, 128, 32, 0, 0, 0.
- R5: Command 0x0B (payload: function code, location) is answered with command 0x08 and length 0x82. The payload is `FUNC_ID`, the location word echoed, and then 128 RAM words in ascending order starting at word address block×128. The block number is location bits [7:0].
- R6: In a command 0x0C frame, payload word 0 is the function code, word 1 is the location, and words 2 to 33 are data. The block is location [7:0] and the quarter is location [17:16]. The 32 data words are written from word address block×128 + quarter×32 upward. This happens only when no word of the frame had `in_bad` set and the function code equals `FUNC_ID`.
- R7: Every command 0x0C frame is answered with command 0x07 and length 0, whether or not the write took place. The answer follows any RAM write.
- R8: Command 0x0D is answered with command 0x07 and length 0.
- R9: Any other command code (for example 0x03) gets no response.
- R10: `warn` is set by a read whose location bits [23:16] are nonzero, or by a write whose length field is not 34 or whose location bits [23:16] exceed 3. Once set, it stays set until reset.
- R11: After reset, `out_valid`, `warn`, `ram_we` and `ram_re` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive word valid |
| in_first | input | 1 | Word is a frame header |
| in_last | input | 1 | Word ends the frame |
| in_bad | input | 1 | Frame damaged (any word) |
| in_data | input | 32 | Receive word |
| in_ready | output | 1 | Block accepts a receive word |
| out_valid | output | 1 | Response word valid |
| out_data | output | 32 | Response word |
| out_last | output | 1 | Final response word |
| out_ready | input | 1 | Transmitter takes the word |
| ram_addr | output | BLK_W+7 | RAM word address |
| ram_re | output | 1 | RAM read; data returns next cycle |
| ram_we | output | 1 | RAM write |
| ram_wdata | output | 32 | RAM write word |
| ram_rdata | input | 32 | RAM read word |
| warn | output | 1 | Sticky irregular-request flag |

## Verification
The hardest case to reach is a block read in which the transmitter stalls at the moment a RAM fetch is outstanding. The fetched word must then land in the output slot and stay there until the transmitter takes it. The bench toggles `out_ready` from a pseudo-random sequence during every response, so the 128 fetched words meet stalls at many different offsets. A reference model predicts each response word from a shadow copy of storage. Damaged and wrong-code writes are each followed by a read of the same block, which shows at the output ports that the RAM did not change.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam logic [7:0] CMD_INFO     = 8'h01;
    localparam logic [7:0] CMD_EXTINFO  = 8'h02;
    localparam logic [7:0] CMD_INFO_RSP = 8'h05;
    localparam logic [7:0] CMD_ACK      = 8'h07;
    localparam logic [7:0] CMD_DATA     = 8'h08;
    localparam logic [7:0] CMD_COND     = 8'h09;
    localparam logic [7:0] CMD_MEMINFO  = 8'h0A;
    localparam logic [7:0] CMD_BREAD    = 8'h0B;
    localparam logic [7:0] CMD_BWRITE   = 8'h0C;
    localparam logic [7:0] CMD_WDONE    = 8'h0D;

    localparam logic [5:0] UNIT_ADDR = 6'h01;
    localparam int BLK_WORDS = 128;
    localparam int WR_WORDS  = 32;
    localparam logic [7:0] WR_LEN    = 8'd34;
    localparam logic [7:0] INFO_LEN  = 8'd28;
    localparam logic [7:0] MEDIA_LEN = 8'd7;
    localparam logic [7:0] READ_LEN  = 8'h82;

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] src;
        logic [7:0] dst;
        logic [7:0] cmd;
    } hdr_t;

    typedef enum logic [1:0] {RK_INFO, RK_MEDIA, RK_READ, RK_ACK} rkind_e;

    function automatic logic [31:0] media_word(input logic [2:0] i, input int unsigned nblk);
        case (i)
            3'd0:    return 32'(nblk - 1);
            3'd1:    return 32'(BLK_WORDS);
            3'd2:    return 32'(WR_WORDS);
            default: return 32'h0;
        endcase
    endfunction
endpackage

// File: rtl/mc_rx_capture.sv
module mc_rx_capture
    import mc_pkg::*;
#(
    parameter int BUF_N = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        in_valid,
    input  logic        in_first,
    input  logic        in_last,
    input  logic        in_bad,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        done,
    output hdr_t        hdr,
    output logic [31:0] fid,
    output logic [31:0] loc,
    output logic        bad,
    output logic [31:0] wbuf [BUF_N]
);
    localparam int BI_W = $clog2(BUF_N);

    typedef struct packed {
        logic        active;
        logic        done;
        logic        bad;
        logic [7:0]  idx;
        hdr_t        hdr;
        logic [31:0] fid;
        logic [31:0] loc;
    } cap_t;

    cap_t cap_d, cap_q;
    logic            buf_we;
    logic [BI_W-1:0] buf_idx;
    logic            acc;

    assign in_ready = en && !cap_q.done;
    assign acc      = in_valid && in_ready;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = 1'b0;
        buf_we     = 1'b0;
        buf_idx    = BI_W'(cap_q.idx - 8'd2);
        if (acc) begin
            if (in_first) begin
                cap_d.active = 1'b1;
                cap_d.hdr    = hdr_t'(in_data);
                cap_d.idx    = 8'd0;
                cap_d.bad    = in_bad;
                cap_d.fid    = 32'h0;
                cap_d.loc    = 32'h0;
            end else if (cap_q.active) begin
                if (cap_q.idx == 8'd0)      cap_d.fid = in_data;
                else if (cap_q.idx == 8'd1) cap_d.loc = in_data;
                else if (cap_q.idx < 8'(BUF_N + 2)) buf_we = 1'b1;
                if (cap_q.idx != 8'hFF) cap_d.idx = cap_q.idx + 8'd1;
                cap_d.bad = cap_q.bad | in_bad;
            end
            if (in_last && (in_first || cap_q.active)) begin
                cap_d.active = 1'b0;
                cap_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    always_ff @(posedge clk) begin
        if (buf_we) wbuf[buf_idx] <= in_data;
    end

    assign done = cap_q.done;
    assign hdr  = cap_q.hdr;
    assign fid  = cap_q.fid;
    assign loc  = cap_q.loc;
    assign bad  = cap_q.bad;
endmodule

// File: rtl/mc_resp_gen.sv
module mc_resp_gen
    import mc_pkg::*;
#(
    parameter int          BLK_W     = 8,
    parameter logic [31:0] FUNC_ID   = 32'h0000_0002,
    parameter logic [31:0] DESC_WORD = 32'h0010_4100,
    parameter logic [31:0] PWR_WORD  = 32'h0082_007C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  rkind_e             kind,
    input  hdr_t               req,
    input  logic [31:0]        loc,
    input  logic               out_ready,
    input  logic [31:0]        ram_rdata,
    output logic               busy,
    output logic               out_valid,
    output logic [31:0]        out_data,
    output logic               out_last,
    output logic               ram_re,
    output logic [BLK_W+6:0]   ram_raddr
);
    localparam int NBLK  = 1 << BLK_W;
    localparam int WO_W  = $clog2(BLK_WORDS);

    typedef struct packed {
        logic        active;
        rkind_e      kind;
        hdr_t        rhdr;
        logic [31:0] loc;
        logic [7:0]  idx;
        logic        pend;
        logic        ov;
        logic [31:0] od;
        logic        ol;
    } gen_t;

    gen_t g_d, g_q;
    logic [7:0]  p;
    logic [31:0] word;
    logic        free;
    logic        is_last;

    always_comb begin
        p       = g_q.idx - 8'd1;
        is_last = (g_q.idx == g_q.rhdr.len);
        word    = 32'h0;
        if (g_q.idx == 8'd0) word = 32'(g_q.rhdr);
        else if (p == 8'd0)  word = FUNC_ID;
        else begin
            unique case (g_q.kind)
                RK_INFO: begin
                    if (p == 8'd1)                    word = DESC_WORD;
                    else if (p == 8'd2 || p == 8'd3)  word = 32'h0;
                    else if (p == 8'd27)              word = PWR_WORD;
                    else                              word = 32'h2020_2020;
                end
                RK_MEDIA: word = media_word(3'(p - 8'd1), NBLK);
                RK_READ:  word = g_q.loc;
                default:  word = 32'h0;
            endcase
        end
    end

    always_comb begin
        g_d       = g_q;
        ram_re    = 1'b0;
        ram_raddr = {g_q.loc[BLK_W-1:0], WO_W'(g_q.idx - 8'd3)};
        free      = !g_q.ov || out_ready;
        if (g_q.ov && out_ready) g_d.ov = 1'b0;
        if (start) begin
            g_d.active = 1'b1;
            g_d.kind   = kind;
            g_d.loc    = loc;
            g_d.idx    = 8'd0;
            g_d.pend   = 1'b0;
            g_d.rhdr.src = req.dst;
            g_d.rhdr.dst = req.src;
            unique case (kind)
                RK_INFO:  begin g_d.rhdr.cmd = CMD_INFO_RSP; g_d.rhdr.len = INFO_LEN;  end
                RK_MEDIA: begin g_d.rhdr.cmd = CMD_DATA;     g_d.rhdr.len = MEDIA_LEN; end
                RK_READ:  begin g_d.rhdr.cmd = CMD_DATA;     g_d.rhdr.len = READ_LEN;  end
                default:  begin g_d.rhdr.cmd = CMD_ACK;      g_d.rhdr.len = 8'd0;      end
            endcase
        end else if (g_q.active) begin
            if (g_q.pend) begin
                g_d.ov   = 1'b1;
                g_d.od   = ram_rdata;
                g_d.ol   = is_last;
                g_d.pend = 1'b0;
                g_d.idx  = g_q.idx + 8'd1;
                if (is_last) g_d.active = 1'b0;
            end else if (free) begin
                if (g_q.kind == RK_READ && g_q.idx >= 8'd3) begin
                    ram_re   = 1'b1;
                    g_d.pend = 1'b1;
                end else begin
                    g_d.ov  = 1'b1;
                    g_d.od  = word;
                    g_d.ol  = is_last;
                    g_d.idx = g_q.idx + 8'd1;
                    if (is_last) g_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign busy      = g_q.active || g_q.ov;
    assign out_valid = g_q.ov;
    assign out_data  = g_q.od;
    assign out_last  = g_q.ol;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R2
    AST_FETCH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> (!out_valid && g_q.pend)); // R5
endmodule

// File: rtl/mc_responder.sv
module mc_responder
    import mc_pkg::*;
#(
    parameter int          BLK_W     = 8,
    parameter logic [31:0] FUNC_ID   = 32'h0000_0002,
    parameter logic [31:0] DESC_WORD = 32'h0010_4100,
    parameter logic [31:0] PWR_WORD  = 32'h0082_007C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_first,
    input  logic               in_last,
    input  logic               in_bad,
    input  logic [31:0]        in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [31:0]        out_data,
    output logic               out_last,
    input  logic               out_ready,
    output logic [BLK_W+6:0]   ram_addr,
    output logic               ram_re,
    output logic               ram_we,
    output logic [31:0]        ram_wdata,
    input  logic [31:0]        ram_rdata,
    output logic               warn
);
    localparam int WC_W = $clog2(WR_WORDS);
    localparam int Q_W  = $clog2(BLK_WORDS / WR_WORDS);

    typedef enum logic [1:0] {S_RX, S_WR, S_RESP} st_e;
    typedef struct packed {
        st_e            st;
        logic [WC_W-1:0] wcnt;
        logic           warn;
    } top_t;

    top_t t_d, t_q;
    logic        cap_done, cap_bad, start, gen_busy;
    hdr_t        cap_hdr;
    logic [31:0] cap_fid, cap_loc;
    logic [31:0] wbuf [WR_WORDS];
    rkind_e      kind;
    logic [BLK_W+6:0] gen_raddr;

    mc_rx_capture #(.BUF_N(WR_WORDS)) u_cap (
        .clk(clk), .rst_n(rst_n), .en(t_q.st == S_RX),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_bad(in_bad), .in_data(in_data), .in_ready(in_ready),
        .done(cap_done), .hdr(cap_hdr), .fid(cap_fid), .loc(cap_loc),
        .bad(cap_bad), .wbuf(wbuf)
    );

    mc_resp_gen #(.BLK_W(BLK_W), .FUNC_ID(FUNC_ID), .DESC_WORD(DESC_WORD),
                  .PWR_WORD(PWR_WORD)) u_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .req(cap_hdr),
        .loc(cap_loc), .out_ready(out_ready), .ram_rdata(ram_rdata),
        .busy(gen_busy), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .ram_re(ram_re), .ram_raddr(gen_raddr)
    );

    always_comb begin
        t_d    = t_q;
        start  = 1'b0;
        kind   = RK_ACK;
        ram_we = 1'b0;
        unique case (t_q.st)
            S_RX: begin
                if (cap_done && cap_hdr.dst[5:0] == UNIT_ADDR) begin
                    case (cap_hdr.cmd)
                        CMD_INFO: begin start = 1'b1; kind = RK_INFO; end
                        CMD_EXTINFO, CMD_COND, CMD_MEMINFO: begin
                            start = 1'b1; kind = RK_MEDIA;
                        end
                        CMD_BREAD: begin
                            start = 1'b1; kind = RK_READ;
                            if (cap_loc[23:16] != 8'd0) t_d.warn = 1'b1;
                        end
                        CMD_BWRITE: begin
                            if (cap_hdr.len != WR_LEN || cap_loc[23:16] > 8'd3) t_d.warn = 1'b1;
                            if (!cap_bad && cap_fid == FUNC_ID) begin
                                t_d.st   = S_WR;
                                t_d.wcnt = '0;
                            end else begin
                                start = 1'b1;
                            end
                        end
                        CMD_WDONE: start = 1'b1;
                        default: ;
                    endcase
                    if (start) t_d.st = S_RESP;
                end
            end
            S_WR: begin
                ram_we   = 1'b1;
                t_d.wcnt = t_q.wcnt + 1'b1;
                if (t_q.wcnt == WC_W'(WR_WORDS - 1)) begin
                    start  = 1'b1;
                    t_d.st = S_RESP;
                end
            end
            default: begin
                if (!gen_busy) t_d.st = S_RX;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{st: S_RX, wcnt: '0, warn: 1'b0};
        else        t_q <= t_d;
    end

    assign ram_wdata = wbuf[t_q.wcnt];
    assign ram_addr  = ram_we ? {cap_loc[BLK_W-1:0], cap_loc[16 +: Q_W], t_q.wcnt} : gen_raddr;
    assign warn      = t_q.warn;

    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        warn |=> warn); // R10
    AST_NO_RX_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R1
    AST_RAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re)); // R6
    AST_WRITE_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we) |-> !in_ready); // R7
endmodule

// File: tb/mc_responder_tb.sv
module mc_responder_tb;
    localparam logic [31:0] FID  = 32'h0000_0002;
    localparam logic [31:0] DESC = 32'h0010_4100;
    localparam logic [31:0] PWR  = 32'h0082_007C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_first = 0, in_last = 0, in_bad = 0;
    logic [31:0] in_data = '0;
    logic in_ready, out_valid, out_last, ram_re, ram_we, warn;
    logic out_ready = 1'b1;
    logic [31:0] out_data, ram_wdata, ram_rdata;
    logic [14:0] ram_addr;

    int checks = 0, fails = 0;
    logic [32:0] expq[$];
    logic [31:0] ram [int];
    logic [31:0] shadow [int];
    logic exp_warn = 1'b0;
    logic stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    mc_responder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_bad(in_bad), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .warn(warn)
    );

    function automatic logic [31:0] seed_word(input int a);
        return 32'hC0DE_0000 ^ (32'(a) * 32'h0000_9E37);
    endfunction

    always @(posedge clk) begin
        if (ram_we) ram[int'(ram_addr)] = ram_wdata;
        if (ram_re) ram_rdata <= ram.exists(int'(ram_addr)) ? ram[int'(ram_addr)]
                                                           : seed_word(int'(ram_addr));
    end

    function automatic logic [31:0] shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : seed_word(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Output monitor: compares every transferred word against the model (R2)
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_en ? lfsr[0] : 1'b1;
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0)
                check(1'b0, "R9/R1 unexpected response word", {31'h0, out_last, out_data}, 64'h0);
            else begin
                logic [32:0] e;
                e = expq.pop_front();
                check({out_last, out_data} == e, "R2 response word",
                      {31'h0, out_last, out_data}, {31'h0, e});
            end
        end
    end

    task automatic push_hdr(input logic [7:0] rcmd, input logic [7:0] rlen,
                            input logic [7:0] qdst, input logic [7:0] qsrc);
        expq.push_back({(rlen == 8'd0), rlen, qdst, qsrc, rcmd});
    endtask

    task automatic model(input logic [7:0] cmd, input logic [7:0] dst, input logic [7:0] src,
                         input logic [7:0] len, input logic [31:0] pl[$], input bit bad);
        logic [31:0] fid, loc;
        fid = (pl.size() > 0) ? pl[0] : 32'h0;
        loc = (pl.size() > 1) ? pl[1] : 32'h0;
        if (dst[5:0] != 6'h01) return;
        case (cmd)
            8'h01: begin
                push_hdr(8'h05, 8'd28, dst, src);
                for (int i = 0; i < 28; i++) begin
                    logic [31:0] w;
                    w = (i == 0) ? FID : (i == 1) ? DESC : (i < 4) ? 32'h0 :
                        (i == 27) ? PWR : 32'h2020_2020;
                    expq.push_back({(i == 27), w});
                end
            end
            8'h02, 8'h09, 8'h0A: begin
                push_hdr(8'h08, 8'd7, dst, src);
                expq.push_back({1'b0, FID});
                expq.push_back({1'b0, 32'd255});
                expq.push_back({1'b0, 32'd128});
                expq.push_back({1'b0, 32'd32});
                expq.push_back({1'b0, 32'd0});
                expq.push_back({1'b0, 32'd0});
                expq.push_back({1'b1, 32'd0});
            end
            8'h0B: begin
                push_hdr(8'h08, 8'h82, dst, src);
                expq.push_back({1'b0, FID});
                expq.push_back({1'b0, loc});
                for (int i = 0; i < 128; i++)
                    expq.push_back({(i == 127), shadow_rd(int'(loc[7:0]) * 128 + i)});
                if (loc[23:16] != 0) exp_warn = 1'b1;
            end
            8'h0C: begin
                if (len != 8'd34 || loc[23:16] > 8'd3) exp_warn = 1'b1;
                if (!bad && fid == FID)
                    for (int i = 0; i < 32; i++)
                        shadow[int'(loc[7:0]) * 128 + int'(loc[17:16]) * 32 + i] = pl[2+i];
                push_hdr(8'h07, 8'd0, dst, src);
            end
            8'h0D: push_hdr(8'h07, 8'd0, dst, src);
            default: ;
        endcase
    endtask

    task automatic send(input logic [7:0] cmd, input logic [7:0] dst, input logic [7:0] src,
                        input logic [7:0] len, input logic [31:0] pl[$], input bit bad);
        int n;
        n = pl.size();
        model(cmd, dst, src, len, pl, bad);
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_first = (i == 0);
            in_last  = (i == n);
            in_bad   = bad && (i == n);
            in_data  = (i == 0) ? {len, src, dst, cmd} : pl[i-1];
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_bad = 1'b0;
        repeat (4) @(negedge clk);
        while (!(in_ready && !out_valid && expq.size() == 0)) @(negedge clk);
        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R2 response complete", 64'(expq.size()), 64'h0);
        check(warn == exp_warn, "R10 warn flag", 64'(warn), 64'(exp_warn));
    endtask

    task automatic wr(input int blk, input int ph, input logic [31:0] fid, input int sd,
                      input bit bad, input logic [7:0] len);
        logic [31:0] pl[$];
        pl.push_back(fid);
        pl.push_back({8'h0, 8'(ph), 8'h0, 8'(blk)});
        for (int i = 0; i < 32; i++) pl.push_back(32'h5000_0000 + 32'(sd * 64 + i));
        send(8'h0C, 8'h01, 8'h00, len, pl, bad);
    endtask

    task automatic rd(input int blk, input int ph, input logic [7:0] dst);
        logic [31:0] pl[$];
        pl.push_back(FID);
        pl.push_back({8'h0, 8'(ph), 8'h0, 8'(blk)});
        send(8'h0B, dst, 8'h00, 8'd2, pl, 1'b0);
    endtask

    task automatic simple(input logic [7:0] cmd, input logic [7:0] dst, input logic [7:0] src);
        logic [31:0] pl[$];
        pl.push_back(FID);
        send(cmd, dst, src, 8'd1, pl, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(out_valid == 0 && warn == 0 && ram_we == 0 && ram_re == 0,
              "R11 reset outputs", {60'h0, out_valid, warn, ram_we, ram_re}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R11 ready after reset", 64'(in_ready), 64'h1);

        simple(8'h01, 8'h01, 8'h00);                 // R3 info
        simple(8'h09, 8'h01, 8'h00);                 // R4 get condition
        simple(8'h0A, 8'h01, 8'h00);                 // R4 memory info
        simple(8'h02, 8'h01, 8'h00);                 // R4 extended info
        stall_en = 1'b1;
        rd(5, 0, 8'h01);                             // R5 read of untouched block
        wr(5, 2, FID, 1, 1'b0, 8'd34);               // R6 R7 good write to quarter 2
        rd(5, 0, 8'h01);                             // R6 readback
        wr(5, 0, FID, 2, 1'b1, 8'd34);               // R6 R7 damaged frame: no write
        wr(5, 1, 32'h0000_0004, 3, 1'b0, 8'd34);     // R6 R7 wrong function code
        rd(5, 0, 8'h01);                             // R6 storage unchanged
        wr(255, 3, FID, 4, 1'b0, 8'd34);             // R6 last block, last quarter
        rd(255, 0, 8'h01);
        simple(8'h0D, 8'h01, 8'h00);                 // R8 write complete
        simple(8'h03, 8'h01, 8'h00);                 // R9 unknown command
        simple(8'h01, 8'h20, 8'h00);                 // R1 wrong unit address
        simple(8'h01, 8'hC1, 8'h5A);                 // R1 R2 port bits, swapped fields
        stall_en = 1'b0;
        simple(8'h09, 8'h41, 8'h00);                 // R2 no stalls
        rd(7, 1, 8'h01);                             // R10 nonzero phase on read
        rst_n = 1'b0; exp_warn = 1'b0;
        @(negedge clk);
        check(warn == 1'b0, "R11 reset clears warn", 64'(warn), 64'h0);
        rst_n = 1'b1;
        wr(9, 0, FID, 5, 1'b0, 8'd35);               // R10 length mismatch, still written
        rd(9, 0, 8'h01);
        rst_n = 1'b0; exp_warn = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wr(10, 5, FID, 6, 1'b1, 8'd34);              // R10 phase above 3 (damaged, no write)
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule